// File: doc/BRIEF.md
# Binary hex record parser

This block takes a stream of raw bytes, one per cycle when a valid strobe is high, and frames it into hex-style records carried in binary rather than as ASCII text. Bytes that fall between records are thrown away until a start mark (3Ah) appears. After the mark the block captures the record header and then the payload, and it checks the record checksum at the end of each record.

Data records produce one write strobe per payload byte, carrying the target address and the byte. The target address is the record address plus a base set by extended-address records. A running sum of the payload bytes is kept for the host side. A valid end record raises a one-cycle completion pulse, so that the surrounding logic can compute a checksum over the written area and return it. Any format violation sets a sticky error flag. From then on the block ignores all input until reset.

Top module: `hexrec_parser`

## Requirements
- R1: After reset, wr_en_o, end_done_o and err_o are 0 and sum_o is 0.
- R2: While the parser is hunting between records, any byte other than 3Ah is discarded. A discarded byte causes no write and no error.
- R3: After the start mark, the bytes arrive in this order: length, address high, address low, type, length data bytes, checksum. For a data record (type 00h), the k-th data byte (counting from k=0) is written with wr_en_o high in the cycle after it is accepted. Its address is the record address + k + base, taken modulo 2^ADDR_W.
- R4: sum_o is the running sum of the data bytes of data records only, taken modulo 2^SUM_W. Length, address, type and checksum bytes are not included, and neither are the bytes of extended-address records.
- R5: A record is valid when the modulo-256 sum of its length, address, type, data and checksum bytes is 00h. Any other value sets err_o in the cycle after the checksum byte.
- R6: A type byte above 02h sets err_o in the cycle after the type byte.
- R7: An end record (type 01h) with a length other than 00h sets err_o after its type byte. An extended-address record (type 02h) with a length other than 02h does the same.
- R8: A valid extended-address record loads its two data bytes, high byte first, as the base value at its checksum byte. Every later data record adds the base value shifted left by 4 to its address.
- R9: A data record whose type byte arrives while the base value is above EXT_LIMIT (default 1000h) sets err_o after the type byte. A base value equal to EXT_LIMIT is accepted.
- R10: A valid end record pulses end_done_o for exactly one cycle, in the cycle after its checksum byte. The parser then hunts for the next start mark.
- R11: Once err_o is set, it stays set until reset. While it is set there are no further writes, no end_done_o pulses and no change to sum_o.
- R12: A data record with length 00h produces no write and goes straight from the type byte to the checksum byte.
- R13: A cycle in which byte_valid_i is low has no effect, whatever value byte_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | byte_i holds a byte to consume this cycle |
| byte_i | input | 8 | Incoming stream byte |
| wr_addr_o | output | ADDR_W | Write address for the payload byte |
| wr_data_o | output | 8 | Payload byte to write |
| wr_en_o | output | 1 | Write strobe, one cycle per data byte |
| end_done_o | output | 1 | One-cycle pulse after a valid end record |
| sum_o | output | SUM_W | Running sum of the payload bytes |
| err_o | output | 1 | Sticky format error |

## Verification
The bench keeps ADDR_W at 16 and EXT_LIMIT at 1000h, and narrows SUM_W to 10. The narrow sum lets a single eight-byte record of FFh carry sum_o past its modulo wrap. The 16-bit address lets a base of exactly 1000h, once shifted left by 4, wrap the write address back to the record address; this same base is the accepted boundary for R9. The bench compares the limit itself with the 1001h case, and runs each error kind from a fresh reset so that the error freeze can be observed at the ports.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;
  typedef enum logic [2:0] {
    ST_HUNT, ST_LEN, ST_AHI, ST_ALO, ST_TYPE, ST_DATA, ST_CSUM, ST_HALT
  } rec_state_e;

  localparam logic [7:0] REC_DATA = 8'h00;
  localparam logic [7:0] REC_END  = 8'h01;
  localparam logic [7:0] REC_EXT  = 8'h02;
  localparam int unsigned EXT_LEN = 2;
endpackage

// File: rtl/hexrec_framer.sv
module hexrec_framer
  import hexrec_pkg::*;
#(
  parameter logic [7:0]  MARK      = 8'h3A,
  parameter logic [15:0] EXT_LIMIT = 16'h1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  input  logic [15:0] ext_base_i,
  output logic        data_stb_o,
  output logic        addr_load_o,
  output logic [15:0] rec_addr_o,
  output logic        ext_commit_o,
  output logic [15:0] ext_val_o,
  output logic        end_done_o,
  output logic        err_o
);
  rec_state_e  state_q;
  logic [7:0]  len_q, ahi_q, type_q, cnt_q, csum_q;
  logic [15:0] ext_sh_q;
  logic        end_q, err_q;
  logic [7:0]  csum_next;
  logic        csum_ok, type_err;

  always_comb begin
    csum_next = csum_q + byte_i;
    csum_ok   = (csum_next == 8'h00);
    type_err  = (byte_i > REC_EXT)
             || (byte_i == REC_END  && len_q != 8'd0)
             || (byte_i == REC_EXT  && len_q != 8'(EXT_LEN))
             || (byte_i == REC_DATA && ext_base_i > EXT_LIMIT);
  end

  assign data_stb_o   = byte_valid_i && state_q == ST_DATA && type_q == REC_DATA;
  assign addr_load_o  = byte_valid_i && state_q == ST_ALO;
  assign rec_addr_o   = {ahi_q, byte_i};
  assign ext_commit_o = byte_valid_i && state_q == ST_CSUM && type_q == REC_EXT && csum_ok;
  assign ext_val_o    = ext_sh_q;
  assign end_done_o   = end_q;
  assign err_o        = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      len_q    <= '0;
      ahi_q    <= '0;
      type_q   <= '0;
      cnt_q    <= '0;
      csum_q   <= '0;
      ext_sh_q <= '0;
      end_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      end_q <= 1'b0;
      if (byte_valid_i) begin
        unique case (state_q)
          ST_HUNT: if (byte_i == MARK) begin
            csum_q  <= '0;
            state_q <= ST_LEN;
          end
          ST_LEN: begin
            len_q   <= byte_i;
            csum_q  <= csum_next;
            state_q <= ST_AHI;
          end
          ST_AHI: begin
            ahi_q   <= byte_i;
            csum_q  <= csum_next;
            state_q <= ST_ALO;
          end
          ST_ALO: begin
            csum_q  <= csum_next;
            state_q <= ST_TYPE;
          end
          ST_TYPE: begin
            if (type_err) begin
              err_q   <= 1'b1;
              state_q <= ST_HALT;
            end else begin
              type_q  <= byte_i;
              cnt_q   <= len_q;
              csum_q  <= csum_next;
              state_q <= (len_q == 8'd0) ? ST_CSUM : ST_DATA;
            end
          end
          ST_DATA: begin
            csum_q   <= csum_next;
            ext_sh_q <= {ext_sh_q[7:0], byte_i};
            cnt_q    <= cnt_q - 8'd1;
            if (cnt_q == 8'd1) state_q <= ST_CSUM;
          end
          ST_CSUM: begin
            if (csum_ok) begin
              end_q   <= (type_q == REC_END);
              state_q <= ST_HUNT;
            end else begin
              err_q   <= 1'b1;
              state_q <= ST_HALT;
            end
          end
          default: state_q <= ST_HALT;
        endcase
      end
    end
  end

  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  // R11
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (!data_stb_o && !ext_commit_o && !end_q));
  // R10
  end_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_q |=> !end_q);
endmodule

// File: rtl/hexrec_addr_gen.sv
module hexrec_addr_gen #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [15:0]       rec_addr_i,
  input  logic              ext_commit_i,
  input  logic [15:0]       ext_val_i,
  input  logic              data_stb_i,
  input  logic [7:0]        byte_i,
  output logic [15:0]       ext_base_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_en_o
);
  localparam int unsigned EXT_SHIFT = 4;

  logic [15:0]       ext_q;
  logic [ADDR_W-1:0] ptr_q, load_val;

  always_comb
    load_val = ADDR_W'(rec_addr_i) + ADDR_W'({ext_q, {EXT_SHIFT{1'b0}}});

  assign ext_base_o = ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q     <= '0;
      ptr_q     <= '0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_en_o   <= 1'b0;
    end else begin
      wr_en_o <= data_stb_i;
      if (ext_commit_i) ext_q <= ext_val_i;
      if (addr_load_i) ptr_q <= load_val;
      else if (data_stb_i) ptr_q <= ptr_q + 1'b1;
      if (data_stb_i) begin
        wr_addr_o <= ptr_q;
        wr_data_o <= byte_i;
      end
    end
  end

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && data_stb_i) |=> (wr_addr_o == $past(wr_addr_o) + 1'b1));
  // R8
  base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_commit_i |=> $stable(ext_q));
endmodule

// File: rtl/hexrec_sum_acc.sv
module hexrec_sum_acc #(
  parameter int unsigned SUM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_stb_i,
  input  logic [7:0]       byte_i,
  output logic [SUM_W-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else if (data_stb_i) sum_o <= sum_o + SUM_W'(byte_i);
  end

  // R4
  sum_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_stb_i |=> $stable(sum_o));
endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SUM_W     = 16,
  parameter logic [7:0]  MARK      = 8'h3A,
  parameter logic [15:0] EXT_LIMIT = 16'h1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_en_o,
  output logic              end_done_o,
  output logic [SUM_W-1:0]  sum_o,
  output logic              err_o
);
  logic        data_stb, addr_load, ext_commit;
  logic [15:0] rec_addr, ext_val, ext_base;

  hexrec_framer #(.MARK(MARK), .EXT_LIMIT(EXT_LIMIT)) u_framer (
    .clk_i, .rst_ni, .byte_valid_i, .byte_i,
    .ext_base_i   (ext_base),
    .data_stb_o   (data_stb),
    .addr_load_o  (addr_load),
    .rec_addr_o   (rec_addr),
    .ext_commit_o (ext_commit),
    .ext_val_o    (ext_val),
    .end_done_o,
    .err_o
  );

  hexrec_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni,
    .addr_load_i  (addr_load),
    .rec_addr_i   (rec_addr),
    .ext_commit_i (ext_commit),
    .ext_val_i    (ext_val),
    .data_stb_i   (data_stb),
    .byte_i,
    .ext_base_o   (ext_base),
    .wr_addr_o, .wr_data_o, .wr_en_o
  );

  hexrec_sum_acc #(.SUM_W(SUM_W)) u_sum (
    .clk_i, .rst_ni,
    .data_stb_i (data_stb),
    .byte_i,
    .sum_o
  );
endmodule

// File: tb/hexrec_parser_tb.sv
module hexrec_parser_tb;
  localparam int SUM_W = 10;
  localparam int SUM_MASK = (1 << SUM_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  data = 8'h00;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_en, end_done, err;
  logic [SUM_W-1:0] sum;

  hexrec_parser #(.ADDR_W(16), .SUM_W(SUM_W), .EXT_LIMIT(16'h1000)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(valid), .byte_i(data),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_en_o(wr_en),
    .end_done_o(end_done), .sum_o(sum), .err_o(err)
  );

  always #5 clk = ~clk;

  int total = 0, fails = 0, wcnt = 0, ecnt = 0, exp_sum = 0;
  bit done = 1'b0;
  logic [15:0] wa [0:63];
  logic [7:0]  wd [0:63];
  logic [7:0]  pl [0:15];

  always @(negedge clk) begin
    if (wr_en && wcnt < 64) begin
      wa[wcnt] = wr_addr;
      wd[wcnt] = wr_data;
    end
    if (wr_en) wcnt = wcnt + 1;
    if (end_done) ecnt = ecnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    valid = 1'b0;
    repeat (2) @(negedge clk);
    wcnt = 0; ecnt = 0; exp_sum = 0;
    rst_n = 1'b1;
    #1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    valid = 1'b1;
    data = b;
    @(negedge clk);
    valid = 1'b0;
    #1;
  endtask

  // sends a full record using pl[0..len-1]; bad=1 corrupts the checksum
  task automatic send_rec(input logic [7:0] len, input logic [15:0] addr,
                          input logic [7:0] typ, input bit bad);
    logic [7:0] cs;
    cs = len + addr[15:8] + addr[7:0] + typ;
    send_byte(8'h3A);
    send_byte(len);
    send_byte(addr[15:8]);
    send_byte(addr[7:0]);
    send_byte(typ);
    for (int i = 0; i < int'(len); i++) begin
      send_byte(pl[i]);
      cs = cs + pl[i];
      if (typ == 8'h00) exp_sum = (exp_sum + int'(pl[i])) & SUM_MASK;
    end
    cs = 8'h00 - cs;
    if (bad) cs = cs + 8'h01;
    send_byte(cs);
  endtask

  task automatic t_reset();
    do_reset();
    chk(wr_en == 1'b0 && end_done == 1'b0 && err == 1'b0, "R1 flags", {wr_en, end_done, err}, 0);
    chk(sum == '0, "R1 sum", int'(sum), 0);
  endtask

  task automatic t_data_basic();
    do_reset();
    send_byte(8'h00); send_byte(8'hFF); send_byte(8'h55);
    chk(wcnt == 0 && err == 1'b0, "R2 junk ignored", wcnt + int'(err), 0);
    pl[0] = 8'hA1; pl[1] = 8'hB2; pl[2] = 8'hC3;
    send_byte(8'h3A); send_byte(8'h03); send_byte(8'h12); send_byte(8'h34); send_byte(8'h00);
    send_byte(pl[0]);
    // R13: stall with a start-mark value on the bus
    data = 8'h3A;
    repeat (3) @(negedge clk);
    #1;
    chk(wcnt == 1, "R13 stall no effect", wcnt, 1);
    send_byte(pl[1]); send_byte(pl[2]);
    send_byte(8'h00 - (8'h03 + 8'h12 + 8'h34 + 8'hA1 + 8'hB2 + 8'hC3));
    exp_sum = (8'hA1 + 8'hB2 + 8'hC3) & SUM_MASK;
    chk(wcnt == 3, "R3 write count", wcnt, 3);
    for (int i = 0; i < 3; i++) begin
      chk(wa[i] == 16'h1234 + 16'(i), "R3 address", int'(wa[i]), 16'h1234 + i);
      chk(wd[i] == pl[i], "R3 data", int'(wd[i]), int'(pl[i]));
    end
    chk(err == 1'b0, "R5 good checksum", int'(err), 0);
    chk(int'(sum) == exp_sum, "R4 sum", int'(sum), exp_sum);
  endtask

  task automatic t_zero_and_wrap();
    do_reset();
    send_rec(8'h00, 16'h0400, 8'h00, 1'b0);
    chk(wcnt == 0 && err == 1'b0, "R12 zero length", wcnt + int'(err), 0);
    for (int i = 0; i < 8; i++) pl[i] = 8'hFF;
    send_rec(8'h08, 16'h0100, 8'h00, 1'b0);
    chk(int'(sum) == exp_sum, "R4 sum wrap", int'(sum), exp_sum);
    chk(wcnt == 8, "R4 wrap writes", wcnt, 8);
  endtask

  task automatic t_ext_end();
    do_reset();
    pl[0] = 8'h01; pl[1] = 8'h00;
    send_rec(8'h02, 16'h0000, 8'h02, 1'b0);
    chk(wcnt == 0 && int'(sum) == 0, "R4 ext bytes excluded", wcnt + int'(sum), 0);
    pl[0] = 8'h5A; pl[1] = 8'h6B;
    send_rec(8'h02, 16'h0010, 8'h00, 1'b0);
    chk(wcnt == 2 && wa[0] == 16'h1010 && wa[1] == 16'h1011, "R8 base applied", int'(wa[0]), 16'h1010);
    pl[0] = 8'h10; pl[1] = 8'h00;
    send_rec(8'h02, 16'h0000, 8'h02, 1'b0);
    pl[0] = 8'h77;
    send_rec(8'h01, 16'h0005, 8'h00, 1'b0);
    chk(err == 1'b0, "R9 limit equal accepted", int'(err), 0);
    chk(wcnt == 3 && wa[2] == 16'h0005, "R8 base wraps address", int'(wa[2]), 16'h0005);
    send_rec(8'h00, 16'h0000, 8'h01, 1'b0);
    chk(ecnt == 1, "R10 end pulse once", ecnt, 1);
    chk(err == 1'b0, "R10 no error", int'(err), 0);
    pl[0] = 8'h11;
    send_rec(8'h01, 16'h0200, 8'h00, 1'b0);
    chk(wcnt == 4 && wd[3] == 8'h11, "R10 hunting resumes", wcnt, 4);
    chk(int'(sum) == exp_sum, "R4 sum after end", int'(sum), exp_sum);
  endtask

  task automatic t_bad_csum();
    do_reset();
    pl[0] = 8'h42;
    send_rec(8'h01, 16'h0300, 8'h00, 1'b1);
    chk(err == 1'b1, "R5 checksum mismatch", int'(err), 1);
    chk(wcnt == 1, "R5 write before check", wcnt, 1);
    pl[0] = 8'h24;
    send_rec(8'h01, 16'h0300, 8'h00, 1'b0);
    send_rec(8'h00, 16'h0000, 8'h01, 1'b0);
    chk(wcnt == 1 && ecnt == 0, "R11 frozen", wcnt + ecnt, 1);
    chk(int'(sum) == 8'h42, "R11 sum frozen", int'(sum), 8'h42);
    chk(err == 1'b1, "R11 sticky", int'(err), 1);
  endtask

  task automatic t_bad_type();
    do_reset();
    send_byte(8'h3A); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    chk(err == 1'b0, "R6 no error before type", int'(err), 0);
    send_byte(8'h03);
    chk(err == 1'b1, "R6 bad type", int'(err), 1);
  endtask

  task automatic t_bad_len();
    do_reset();
    send_byte(8'h3A); send_byte(8'h01); send_byte(8'h00); send_byte(8'h00); send_byte(8'h01);
    chk(err == 1'b1, "R7 end length", int'(err), 1);
    do_reset();
    send_byte(8'h3A); send_byte(8'h01); send_byte(8'h00); send_byte(8'h00); send_byte(8'h02);
    chk(err == 1'b1, "R7 ext length", int'(err), 1);
  endtask

  task automatic t_ext_limit();
    do_reset();
    pl[0] = 8'h10; pl[1] = 8'h01;
    send_rec(8'h02, 16'h0000, 8'h02, 1'b0);
    chk(err == 1'b0, "R9 ext record ok", int'(err), 0);
    send_byte(8'h3A); send_byte(8'h01); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    chk(err == 1'b1, "R9 above limit", int'(err), 1);
    send_byte(8'h99);
    chk(wcnt == 0, "R11 no write after error", wcnt, 0);
  endtask

  initial begin
    t_reset();
    t_data_basic();
    t_zero_and_wrap();
    t_ext_end();
    t_bad_csum();
    t_bad_type();
    t_bad_len();
    t_ext_limit();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R13 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule